// File: doc/BRIEF.md
# Nibble ALU Datapath with Dual Register Banks

This block is the arithmetic core of a small 4-bit calculator processor. It has two banks of four nibble registers. Each bank feeds one ALU operand over a private path, so the shared bus only ever loads registers and never drives the ALU. Each bank has its own write port. That port takes a nibble from the bus and writes it into the register picked by the bank's write select. Each bank also has its own read select, which picks the register presented to the ALU and to the display pins.

The ALU is purely combinational. Its result is held in a result latch, and a later instruction can drive that latch onto the bus. Capturing and driving are exclusive: if both are requested in the same cycle, the drive wins and the capture is dropped. A separate carry latch stores the ALU carry (or borrow) only when its strobe is given. The stored value is the carry-in of every following operation, so numbers wider than one nibble can be processed one nibble at a time. The control unit sequences these steps; this block has no state machine of its own.

Top module: `nib_datapath`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the result latch and the carry latch to 0.
- R2: When a bank's write enable is high at a clock edge, `bus_in` is stored in the register chosen by that bank's 2-bit write select. The bank's display pin shows the register chosen by its read select, combinationally.
- R3: A bank whose write enable is low keeps all four registers, and a write to one bank leaves the other bank unchanged.
- R4: Opcode 3'b000 adds operand A, operand B and the stored carry. The result is the low 4 bits of the sum, and the carry out is bit 4.
- R5: Opcode 3'b001 subtracts operand B and the stored carry from operand A, modulo 16. The carry out is 1 exactly when a borrow occurs.
- R6: Opcodes 3'b010 AND, 3'b011 OR, 3'b100 XOR, 3'b101 pass A, 3'b110 pass B and 3'b111 invert A produce carry out 0.
- R7: The result latch loads the ALU output only at an edge where `res_cap` is high and `res_oe` is low. Otherwise it holds its value.
- R8: The carry latch loads the ALU carry out only at an edge where `cy_cap` is high. Otherwise it holds its value.
- R9: With `res_oe` high, `bus_out` shows the result latch and `bus_vld` is 1. With `res_oe` low, `bus_out` is 0 and `bus_vld` is 0.
- R10: A register written at an edge still reads its old value before that edge, and reads the new value after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_in | input | 4 | Bus nibble to load into a register |
| a_we | input | 1 | Write enable, bank A |
| a_wsel | input | 2 | Write register select, bank A |
| a_rsel | input | 2 | Read register select, bank A (operand A) |
| b_we | input | 1 | Write enable, bank B |
| b_wsel | input | 2 | Write register select, bank B |
| b_rsel | input | 2 | Read register select, bank B (operand B) |
| alu_op | input | 3 | ALU opcode |
| res_cap | input | 1 | Result latch capture strobe |
| cy_cap | input | 1 | Carry latch capture strobe |
| res_oe | input | 1 | Drive the result latch onto the bus |
| bus_out | output | 4 | Result nibble toward the bus |
| bus_vld | output | 1 | High when `bus_out` is driving |
| disp_a | output | 4 | Selected bank A register, for the display |
| disp_b | output | 4 | Selected bank B register, for the display |
| cy_q | output | 1 | Stored carry |

## Verification
Directed cases cover the edges of the arithmetic. The pair 0xF plus 0x1 checks the nibble wraparound and the carry out. A following 0 plus 0 shows that the stored carry really is used as carry-in. The pair 0x0 minus 0x1 checks the borrow, and capture and drive requested together check the priority rule. Random stimulus under a fixed seed then mixes writes to both banks, all eight opcodes and every combination of the three strobes. This separates wrong operand routing, a carry captured without its strobe, and writes that leak into the other bank or the wrong register.

// File: rtl/nib_pkg.sv
package nib_pkg;
    parameter int NIB_W = 4;
    parameter int BANK_N = 4;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_AND   = 3'd2,
        OP_OR    = 3'd3,
        OP_XOR   = 3'd4,
        OP_PASSA = 3'd5,
        OP_PASSB = 3'd6,
        OP_NOTA  = 3'd7
    } alu_op_e;
endpackage

// File: rtl/nib_regbank.sv
module nib_regbank #(
    parameter int W = 4,
    parameter int N = 4,
    localparam int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [SW-1:0] wsel,
    input  logic [W-1:0]  wdata,
    input  logic [SW-1:0] rsel,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] regs [N];

    // one write decoder and storage element per register
    for (genvar g = 0; g < N; g++) begin : g_reg
        logic hit;
        assign hit = we && (wsel == SW'(g));
        always_ff @(posedge clk) begin
            if (hit) regs[g] <= wdata;
        end
    end

    assign rdata = regs[rsel];

    // R2
    wr_lands_chk: assert property (@(posedge clk)
        we |=> (regs[$past(wsel)] == $past(wdata)));

    // R3
    no_wr_hold_chk: assert property (@(posedge clk)
        !we |=> (regs[$past(rsel)] == $past(rdata)));
endmodule

// File: rtl/nib_alu.sv
module nib_alu
    import nib_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         cin,
    input  alu_op_e      op,
    output logic [W-1:0] res,
    output logic         cout
);
    logic [W:0] wide;
    logic [W:0] ea, eb, ec;

    assign ea = {1'b0, opa};
    assign eb = {1'b0, opb};
    assign ec = {{W{1'b0}}, cin};

    always_comb begin
        unique case (op)
            OP_ADD:   wide = ea + eb + ec;
            OP_SUB:   wide = ea - eb - ec;
            OP_AND:   wide = {1'b0, opa & opb};
            OP_OR:    wide = {1'b0, opa | opb};
            OP_XOR:   wide = {1'b0, opa ^ opb};
            OP_PASSA: wide = ea;
            OP_PASSB: wide = eb;
            OP_NOTA:  wide = {1'b0, ~opa};
            default:  wide = '0;
        endcase
    end

    assign res  = wide[W-1:0];
    assign cout = wide[W];
endmodule

// File: rtl/nib_latches.sv
module nib_latches #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] alu_res,
    input  logic         alu_cout,
    input  logic         res_cap,
    input  logic         cy_cap,
    input  logic         res_oe,
    output logic [W-1:0] bus_out,
    output logic         bus_vld,
    output logic         cy_q
);
    logic [W-1:0] res_q;
    logic         take_res;

    assign take_res = res_cap && !res_oe;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            cy_q  <= 1'b0;
        end else begin
            if (take_res) res_q <= alu_res;
            if (cy_cap)   cy_q  <= alu_cout;
        end
    end

    assign bus_out = res_oe ? res_q : '0;
    assign bus_vld = res_oe;

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (res_q == '0 && cy_q == 1'b0));

    // R7
    res_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(res_cap && !res_oe) |=> $stable(res_q));

    // R8
    cy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cy_cap |=> $stable(cy_q));

    // R9
    bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_vld |-> (bus_out == '0));
endmodule

// File: rtl/nib_datapath.sv
module nib_datapath
    import nib_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] bus_in,
    input  logic       a_we,
    input  logic [1:0] a_wsel,
    input  logic [1:0] a_rsel,
    input  logic       b_we,
    input  logic [1:0] b_wsel,
    input  logic [1:0] b_rsel,
    input  logic [2:0] alu_op,
    input  logic       res_cap,
    input  logic       cy_cap,
    input  logic       res_oe,
    output logic [3:0] bus_out,
    output logic       bus_vld,
    output logic [3:0] disp_a,
    output logic [3:0] disp_b,
    output logic       cy_q
);
    logic [NIB_W-1:0] opa, opb, alu_res;
    logic             alu_cout;

    nib_regbank #(.W(NIB_W), .N(BANK_N)) u_bank_a (
        .clk(clk), .we(a_we), .wsel(a_wsel), .wdata(bus_in),
        .rsel(a_rsel), .rdata(opa)
    );

    nib_regbank #(.W(NIB_W), .N(BANK_N)) u_bank_b (
        .clk(clk), .we(b_we), .wsel(b_wsel), .wdata(bus_in),
        .rsel(b_rsel), .rdata(opb)
    );

    nib_alu #(.W(NIB_W)) u_alu (
        .opa(opa), .opb(opb), .cin(cy_q), .op(alu_op_e'(alu_op)),
        .res(alu_res), .cout(alu_cout)
    );

    nib_latches #(.W(NIB_W)) u_lat (
        .clk(clk), .rst(rst), .alu_res(alu_res), .alu_cout(alu_cout),
        .res_cap(res_cap), .cy_cap(cy_cap), .res_oe(res_oe),
        .bus_out(bus_out), .bus_vld(bus_vld), .cy_q(cy_q)
    );

    assign disp_a = opa;
    assign disp_b = opb;
endmodule

// File: tb/test_nib_datapath.sv
module test_nib_datapath;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_in = '0;
    logic       a_we = 0, b_we = 0, res_cap = 0, cy_cap = 0, res_oe = 0;
    logic [1:0] a_wsel = 0, a_rsel = 0, b_wsel = 0, b_rsel = 0;
    logic [2:0] alu_op = 0;
    logic [3:0] bus_out, disp_a, disp_b;
    logic       bus_vld, cy_q;

    int checks = 0, fails = 0;
    logic [3:0] ma [4];
    logic [3:0] mb [4];
    logic [3:0] mres;
    logic       mcy;

    always #2 clk = ~clk;

    nib_datapath i_nib_datapath (.*);

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected ALU value {cout, res} from the requirement table
    function automatic logic [4:0] ref_alu(logic [2:0] op, logic [3:0] a, logic [3:0] b, logic c);
        int s;
        case (op)
            3'd0: begin s = a + b + c; return 5'(s); end
            3'd1: begin s = a - b - c; return {s < 0, 4'(s)}; end
            3'd2: return {1'b0, a & b};
            3'd3: return {1'b0, a | b};
            3'd4: return {1'b0, a ^ b};
            3'd5: return {1'b0, a};
            3'd6: return {1'b0, b};
            default: return {1'b0, ~a};
        endcase
    endfunction

    // inputs already driven at the falling edge; check, clock, update model
    task automatic step(string tag);
        logic [4:0] e;
        #1;
        chk({tag, " R2 disp_a"}, {4'h0, disp_a}, {4'h0, ma[a_rsel]});
        chk({tag, " R2 disp_b"}, {4'h0, disp_b}, {4'h0, mb[b_rsel]});
        chk({tag, " R9 bus"}, {3'b0, bus_vld, bus_out}, res_oe ? {4'b0001, mres} : 8'h00);
        chk({tag, " R8 cy"}, {7'b0, cy_q}, {7'b0, mcy});
        e = ref_alu(alu_op, ma[a_rsel], mb[b_rsel], mcy);
        @(posedge clk);
        if (res_cap && !res_oe) mres = e[3:0];
        if (cy_cap) mcy = e[4];
        if (a_we) ma[a_wsel] = bus_in;
        if (b_we) mb[b_wsel] = bus_in;
        @(negedge clk);
    endtask

    task automatic idle();
        a_we = 0; b_we = 0; res_cap = 0; cy_cap = 0; res_oe = 0;
    endtask

    task automatic load(logic bank, logic [1:0] sel, logic [3:0] v);
        idle();
        bus_in = v;
        if (bank) begin b_we = 1; b_wsel = sel; end
        else begin a_we = 1; a_wsel = sel; end
        step("load");
    endtask

    initial begin
        int unsigned seed = 32'd12345;
        void'($urandom(seed));
        for (int i = 0; i < 4; i++) begin ma[i] = 0; mb[i] = 0; end
        mres = 0; mcy = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: latches cleared
        res_oe = 1;
        #1;
        chk("R1 result after reset", {3'b0, bus_vld, bus_out}, 8'h10);
        chk("R1 carry after reset", {7'b0, cy_q}, 8'h00);
        res_oe = 0;
        for (int i = 0; i < 4; i++) begin load(0, 2'(i), 4'h0); load(1, 2'(i), 4'h0); end

        // R4: F + 1 wraps with carry, then 0+0+carry gives 1
        load(0, 0, 4'hF); load(1, 0, 4'h1);
        idle(); a_rsel = 0; b_rsel = 0; alu_op = 3'd0; res_cap = 1; cy_cap = 1; step("R4 add");
        idle(); res_oe = 1; #1;
        chk("R4 add wrap", {3'b0, bus_vld, bus_out}, 8'h10);
        chk("R4 carry set", {7'b0, cy_q}, 8'h01);
        step("R4 read");
        load(0, 1, 4'h0); load(1, 1, 4'h0);
        idle(); a_rsel = 1; b_rsel = 1; alu_op = 3'd0; res_cap = 1; cy_cap = 1; step("R4 chain");
        idle(); res_oe = 1; #1;
        chk("R4 carry-in used", {3'b0, bus_vld, bus_out}, 8'h11);
        step("R4 read2");

        // R5: 0 - 1 borrows
        idle(); a_rsel = 1; b_rsel = 0; alu_op = 3'd1; res_cap = 1; cy_cap = 1; step("R5 sub");
        idle(); res_oe = 1; #1;
        chk("R5 sub wrap", {3'b0, bus_vld, bus_out}, 8'h1F);
        chk("R5 borrow", {7'b0, cy_q}, 8'h01);
        step("R5 read");

        // R7: capture and drive together -> no capture
        idle(); alu_op = 3'd5; a_rsel = 0; res_cap = 1; res_oe = 1; step("R7 both");
        idle(); res_oe = 1; #1;
        chk("R7 result held", {3'b0, bus_vld, bus_out}, 8'h1F);
        step("R7 read");

        // R3/R10: write bank A reg 2; bank B untouched; old value before edge
        idle(); a_rsel = 2; b_rsel = 2; bus_in = 4'h9; a_we = 1; a_wsel = 2; #1;
        chk("R10 old value before edge", {4'h0, disp_a}, 8'h00);
        step("R10 wr");
        idle(); #1;
        chk("R10 new value after edge", {4'h0, disp_a}, 8'h09);
        chk("R3 other bank unchanged", {4'h0, disp_b}, 8'h00);

        // R6: logic ops clear carry
        load(1, 3, 4'h5);
        idle(); a_rsel = 2; b_rsel = 3; alu_op = 3'd2; cy_cap = 1; res_cap = 1; step("R6 and");
        idle(); res_oe = 1; #1;
        chk("R6 and result", {3'b0, bus_vld, bus_out}, 8'h11);
        chk("R6 carry zero", {7'b0, cy_q}, 8'h00);
        step("R6 read");

        // random mix
        for (int n = 0; n < 400; n++) begin
            bus_in = 4'($urandom); alu_op = 3'($urandom);
            a_we = 1'($urandom); b_we = 1'($urandom);
            a_wsel = 2'($urandom); b_wsel = 2'($urandom);
            a_rsel = 2'($urandom); b_rsel = 2'($urandom);
            res_cap = 1'($urandom); cy_cap = 1'($urandom); res_oe = 1'($urandom);
            step("rand R2 R3 R4 R5 R6 R7 R8 R9");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule